// File: doc/BRIEF.md
# Slow-Domain Indirect Register Window

This block gives a CPU on a fast register bus access to registers that live in a slow, always-on timekeeping clock domain. It does not map those registers directly. It offers a four-register window instead. Software stages the target address, a mode word and, for writes, the write data. It then sets a start bit. While the access travels to the slow domain and back, the start register reads as busy.

The request crosses into the slow clock as a toggle and passes through a two-flop synchronizer. The slow-domain engine issues a single-cycle strobe to the target and captures the target's read word. It then returns a toggle acknowledge, which is synchronized back into the CPU clock. When the acknowledge arrives, busy clears. For a read, the returned word is placed in the data register at the same moment. Address, data and lane enables come straight from the staged registers. They cannot change while an access is in flight.

Top module: `slowbrg_window_bridge`

## Requirements
- R1: After reset, all four window registers read zero, busy is clear, and no slow-side strobe is issued.
- R2: Window offsets are 0x0 (start/busy), 0x4 (mode), 0x8 (target address) and 0xC (data). The bus has no wait states: `pready` is high and read data is valid in the access phase. Mode bit 0 is the write flag and bits 7:4 are the lane enables; mode bits 3:1 read as zero.
- R3: Writing a word with bit 0 set to offset 0x0 while idle launches exactly one slow-side access. Offset 0x0 then reads 1 until the access has returned, and 0 afterwards.
- R4: A launch with mode write flag 0 reads the target. Once offset 0x0 reads 0, offset 0xC holds the target word.
- R5: A launch with mode write flag 1 writes the data register to the target. Only the byte lanes whose enable bit (mode bit 4 + lane) is set are updated. Mode 0xF1 writes the full word.
- R6: While busy, writes to the mode, address and data registers are dropped, and a further start is ignored.
- R7: The slow-side strobe lasts one slow clock per launch. The address, data, lane enables and write flag it presents equal the staged values, and they stay stable for as long as busy is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-side clock |
| rst | input | 1 | CPU-side synchronous reset, active high |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write when high |
| paddr | input | 4 | Byte offset in the window |
| pwdata | input | 32 | Bus write data |
| prdata | output | 32 | Bus read data |
| pready | output | 1 | Bus ready, always high |
| far_clk | input | 1 | Slow-domain clock |
| far_rst | input | 1 | Slow-domain synchronous reset, asserted together with rst |
| far_en | output | 1 | One-cycle access strobe to the target |
| far_addr | output | AW | Target register address |
| far_wdata | output | 32 | Target write data |
| far_lanes | output | 4 | Target byte-lane enables |
| far_wr | output | 1 | Target write when high |
| far_rdata | input | 32 | Target read word, valid while far_en is high |

## Verification
Window register writes take effect at the CPU edge that ends the access phase. Window reads are due within that same access phase, so the bench samples `prdata` half a cycle into it. A launched access comes back only after two slow-clock synchronizer stages, one strobe cycle and two CPU synchronizer stages. For that reason the bench reads busy just after each start, which is far inside that window. It then polls offset 0x0 under a bounded count and does not assume a fixed latency. Target-side effects are checked through later window reads, and the strobe count is taken on the slow clock.

// File: rtl/slowbrg_pkg.sv
`timescale 1ns/1ps
package slowbrg_pkg;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [1:0] {
        SEL_START = 2'd0,
        SEL_MODE  = 2'd1,
        SEL_ADDR  = 2'd2,
        SEL_DATA  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        reg_sel_e sel;
    } reg_dec_t;

    typedef struct packed {
        logic [LANES-1:0] lanes;
        logic [2:0]       spare;
        logic             wr;
    } mode_word_t;

    function automatic reg_dec_t decode_off(input logic [3:0] off);
        reg_dec_t d;
        d.hit = (off[1:0] == 2'b00);
        d.sel = reg_sel_e'(off[3:2]);
        return d;
    endfunction
endpackage

// File: rtl/slowbrg_sync2.sv
`timescale 1ns/1ps
module slowbrg_sync2 (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [1:0] stage;

    always_ff @(posedge clk) begin
        if (rst) stage <= '0;
        else     stage <= {stage[0], d};
    end

    assign q = stage[1];
endmodule

// File: rtl/slowbrg_far_engine.sv
`timescale 1ns/1ps
module slowbrg_far_engine
    import slowbrg_pkg::*;
(
    input  logic              far_clk,
    input  logic              far_rst,
    input  logic              req_seen,
    input  logic [DATA_W-1:0] far_rdata,
    output logic              far_en,
    output logic              ack_tog,
    output logic [DATA_W-1:0] rdata_hold
);
    logic req_last;

    // a change of the synchronized request toggle is one new access
    assign far_en = req_seen ^ req_last;

    always_ff @(posedge far_clk) begin
        if (far_rst) begin
            req_last   <= 1'b0;
            ack_tog    <= 1'b0;
            rdata_hold <= '0;
        end else begin
            req_last <= req_seen;
            if (far_en) begin
                rdata_hold <= far_rdata;
                ack_tog    <= ~ack_tog;
            end
        end
    end
endmodule

// File: rtl/slowbrg_cpu_regs.sv
`timescale 1ns/1ps
module slowbrg_cpu_regs
    import slowbrg_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [3:0]        paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic              ack_seen,
    input  logic [DATA_W-1:0] ret_data,
    output logic              req_tog,
    output logic              busy,
    output logic [AW-1:0]     stg_addr,
    output logic [DATA_W-1:0] stg_data,
    output logic [LANES-1:0]  stg_lanes,
    output logic              stg_wr
);
    reg_dec_t   dec;
    mode_word_t mode_in;
    mode_word_t mode_out;
    logic       wr_access;
    logic       ack_last;
    logic       done;

    assign dec       = decode_off(paddr);
    assign mode_in   = mode_word_t'(pwdata[7:0]);
    assign wr_access = psel && penable && pwrite && dec.hit;
    assign done      = ack_seen ^ ack_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_last  <= 1'b0;
            req_tog   <= 1'b0;
            busy      <= 1'b0;
            stg_addr  <= '0;
            stg_data  <= '0;
            stg_lanes <= '0;
            stg_wr    <= 1'b0;
        end else begin
            ack_last <= ack_seen;
            if (done) begin
                busy <= 1'b0;
                if (!stg_wr) stg_data <= ret_data;
            end else if (wr_access && !busy) begin
                case (dec.sel)
                    SEL_START: if (pwdata[0]) begin
                        busy    <= 1'b1;
                        req_tog <= ~req_tog;
                    end
                    SEL_MODE: begin
                        stg_lanes <= mode_in.lanes;
                        stg_wr    <= mode_in.wr;
                    end
                    SEL_ADDR: stg_addr <= pwdata[AW-1:0];
                    SEL_DATA: stg_data <= pwdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        mode_out = '{lanes: stg_lanes, spare: 3'b000, wr: stg_wr};
        prdata   = '0;
        if (dec.hit) begin
            case (dec.sel)
                SEL_START: prdata[0]      = busy;
                SEL_MODE:  prdata[7:0]    = mode_out;
                SEL_ADDR:  prdata[AW-1:0] = stg_addr;
                SEL_DATA:  prdata         = stg_data;
                default:   prdata         = '0;
            endcase
        end
    end
endmodule

// File: rtl/slowbrg_window_bridge.sv
`timescale 1ns/1ps
module slowbrg_window_bridge
    import slowbrg_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [3:0]        paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    input  logic              far_clk,
    input  logic              far_rst,
    output logic              far_en,
    output logic [AW-1:0]     far_addr,
    output logic [DATA_W-1:0] far_wdata,
    output logic [LANES-1:0]  far_lanes,
    output logic              far_wr,
    input  logic [DATA_W-1:0] far_rdata
);
    logic              req_tog;
    logic              req_seen;
    logic              ack_tog;
    logic              ack_seen;
    logic              busy;
    logic [DATA_W-1:0] rdata_hold;

    assign pready = 1'b1;

    slowbrg_cpu_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .pwdata    (pwdata),
        .prdata    (prdata),
        .ack_seen  (ack_seen),
        .ret_data  (rdata_hold),
        .req_tog   (req_tog),
        .busy      (busy),
        .stg_addr  (far_addr),
        .stg_data  (far_wdata),
        .stg_lanes (far_lanes),
        .stg_wr    (far_wr)
    );

    slowbrg_sync2 u_req_sync (
        .clk (far_clk),
        .rst (far_rst),
        .d   (req_tog),
        .q   (req_seen)
    );

    slowbrg_far_engine u_far (
        .far_clk    (far_clk),
        .far_rst    (far_rst),
        .req_seen   (req_seen),
        .far_rdata  (far_rdata),
        .far_en     (far_en),
        .ack_tog    (ack_tog),
        .rdata_hold (rdata_hold)
    );

    slowbrg_sync2 u_ack_sync (
        .clk (clk),
        .rst (rst),
        .d   (ack_tog),
        .q   (ack_seen)
    );
endmodule

// File: rtl/slowbrg_checker.sv
`timescale 1ns/1ps
module slowbrg_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          psel,
    input logic          penable,
    input logic          pwrite,
    input logic [3:0]    paddr,
    input logic [31:0]   pwdata,
    input logic          busy,
    input logic          far_clk,
    input logic          far_rst,
    input logic          far_en,
    input logic [AW-1:0] far_addr,
    input logic [31:0]   far_wdata,
    input logic [3:0]    far_lanes,
    input logic          far_wr
);
    logic bus_wr;
    assign bus_wr = psel && penable && pwrite;

    // R3: an idle start raises busy on the next edge
    assert_launch_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && paddr == 4'h0 && pwdata[0] && !busy) |=> busy);

    // R6: staged address and mode are frozen against bus writes while busy
    assert_locked_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && bus_wr && (paddr == 4'h8 || paddr == 4'h4))
        |=> ($stable(far_addr) && $stable(far_lanes) && $stable(far_wr)));

    // R7: target-side fields hold steady while the access is in flight
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || ($stable(far_addr) && $stable(far_wdata)
                            && $stable(far_lanes) && $stable(far_wr))));

    // R7: the strobe is a single slow-clock pulse
    assert_pulse_R7: assert property (@(posedge far_clk) disable iff (far_rst)
        far_en |=> !far_en);
endmodule

bind slowbrg_window_bridge slowbrg_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .pwdata    (pwdata),
    .busy      (busy),
    .far_clk   (far_clk),
    .far_rst   (far_rst),
    .far_en    (far_en),
    .far_addr  (far_addr),
    .far_wdata (far_wdata),
    .far_lanes (far_lanes),
    .far_wr    (far_wr)
);

// File: tb/slowbrg_window_bridge_bench.sv
`timescale 1ns/1ps
module slowbrg_window_bridge_bench;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          far_clk = 1'b0;
    logic          rst = 1'b1;
    logic          psel = 1'b0;
    logic          penable = 1'b0;
    logic          pwrite = 1'b0;
    logic [3:0]    paddr = '0;
    logic [31:0]   pwdata = '0;
    logic [31:0]   prdata;
    logic          pready;
    logic          far_en;
    logic [AW-1:0] far_addr;
    logic [31:0]   far_wdata;
    logic [3:0]    far_lanes;
    logic          far_wr;
    logic [31:0]   far_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;
    always #18.5 far_clk = ~far_clk;

    slowbrg_window_bridge #(.AW(AW)) u_slowbrg_window_bridge (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .far_clk(far_clk), .far_rst(rst), .far_en(far_en), .far_addr(far_addr),
        .far_wdata(far_wdata), .far_lanes(far_lanes), .far_wr(far_wr),
        .far_rdata(far_rdata)
    );

    // slow-side target model
    logic [31:0]   tgt_mem [16];
    int            hits = 0;
    logic [AW-1:0] seen_addr;
    logic [3:0]    seen_lanes;
    logic [31:0]   seen_wdata;
    assign far_rdata = tgt_mem[far_addr[3:0]];

    function automatic logic [31:0] init_val(input int i);
        return 32'hA5C3_0000 ^ (i * 32'h0101_1357);
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] lanes);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (lanes[b]) r[8*b +: 8] = nw[8*b +: 8];
        return r;
    endfunction

    always @(posedge far_clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) tgt_mem[i] <= init_val(i);
        end else if (far_en) begin
            hits       <= hits + 1;
            seen_addr  <= far_addr;
            seen_lanes <= far_lanes;
            seen_wdata <= far_wdata;
            if (far_wr) tgt_mem[far_addr[3:0]] <= merge(tgt_mem[far_addr[3:0]], far_wdata, far_lanes);
        end
    end

    logic [31:0] exp_mem [16];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1;
        d = prdata;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] v = 32'd1;
        int n = 0;
        while (v != 0 && n < 400) begin bus_rd(4'h0, v); n++; end
        check(req, v, 32'd0);
    endtask

    task automatic launch(input string req);
        logic [31:0] v;
        bus_wr(4'h0, 32'h1);
        bus_rd(4'h0, v);
        check(req, v, 32'd1); // busy right after start (R3)
        wait_idle(req);
    endtask

    task automatic tgt_read(input logic [3:0] a, output logic [31:0] d);
        bus_wr(4'h4, 32'h00);
        bus_wr(4'h8, {28'd0, a});
        launch("R3 read launch");
        bus_rd(4'hC, d);
    endtask

    task automatic tgt_write(input logic [3:0] a, input logic [31:0] d, input logic [3:0] lanes);
        bus_wr(4'h4, {24'd0, lanes, 4'b0001});
        bus_wr(4'h8, {28'd0, a});
        bus_wr(4'hC, d);
        launch("R3 write launch");
        exp_mem[a] = merge(exp_mem[a], d, lanes);
    endtask

    initial begin
        logic [31:0] v;
        int h0;
        for (int i = 0; i < 16; i++) exp_mem[i] = init_val(i);
        void'($urandom(32'd4242));
        repeat (4) @(posedge far_clk);
        @(negedge clk); rst = 0;

        // R1: reset state
        bus_rd(4'h0, v); check("R1 start reg", v, 0);
        bus_rd(4'h4, v); check("R1 mode reg", v, 0);
        bus_rd(4'h8, v); check("R1 addr reg", v, 0);
        bus_rd(4'hC, v); check("R1 data reg", v, 0);
        check("R1 no strobe", hits, 0);

        // R2: map, readback, spare bits, ready
        bus_wr(4'h4, 32'hFF); bus_rd(4'h4, v); check("R2 mode spare zero", v, 32'hF1);
        bus_wr(4'h8, 32'hFFFF_1234); bus_rd(4'h8, v); check("R2 addr width", v, 32'h1234);
        bus_wr(4'hC, 32'hDEAD_BEEF); bus_rd(4'hC, v); check("R2 data readback", v, 32'hDEADBEEF);
        check("R2 pready", {31'd0, pready}, 1);

        // R4 / R3: single read, one strobe
        h0 = hits;
        tgt_read(4'd3, v);
        check("R4 read word", v, exp_mem[3]);
        check("R3 one strobe", hits - h0, 1);

        // R5: full word write, R7 presented fields
        tgt_write(4'd5, 32'h1357_9BDF, 4'hF);
        check("R7 seen addr", {16'd0, seen_addr}, 32'd5);
        check("R7 seen lanes", {28'd0, seen_lanes}, 32'hF);
        check("R7 seen wdata", seen_wdata, 32'h13579BDF);
        tgt_read(4'd5, v); check("R5 full write", v, exp_mem[5]);

        // R5: partial lanes
        tgt_write(4'd6, 32'h1122_3344, 4'b0101);
        tgt_read(4'd6, v); check("R5 lanes 0101", v, exp_mem[6]);
        tgt_write(4'd6, 32'hAABB_CCDD, 4'b1000);
        tgt_read(4'd6, v); check("R5 lane 3 only", v, exp_mem[6]);

        // R6: writes and restart ignored while busy
        bus_wr(4'h4, 32'h00);
        bus_wr(4'h8, 32'd7);
        h0 = hits;
        bus_wr(4'h0, 32'h1);
        bus_wr(4'h8, 32'd9);
        bus_wr(4'h4, 32'hF1);
        bus_wr(4'hC, 32'h1111_1111);
        bus_wr(4'h0, 32'h1);
        wait_idle("R6 idle");
        repeat (20) @(negedge clk);
        check("R6 one strobe", hits - h0, 1);
        bus_rd(4'h8, v); check("R6 addr kept", v, 32'd7);
        bus_rd(4'h4, v); check("R6 mode kept", v, 32'd0);
        bus_rd(4'hC, v); check("R6 data is read result", v, exp_mem[7]);
        check("R7 strobe addr", {16'd0, seen_addr}, 32'd7);

        // random mix
        for (int k = 0; k < 40; k++) begin
            logic [3:0]  a  = 4'($urandom_range(0, 15));
            logic [31:0] d  = $urandom;
            logic [3:0]  ln = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 1) == 1) tgt_write(a, d, ln);
            else begin
                tgt_read(a, v);
                check("R4 random read", v, exp_mem[a]);
            end
        end
        for (int i = 0; i < 16; i++) begin
            tgt_read(4'(i), v);
            check("R5 final sweep", v, exp_mem[i]);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule